// File: doc/BRIEF.md
# TDM Slot Transmitter

This block returns processed audio samples to an external codec over a time-division-multiplexed serial link. The codec is the timing master. It drives the bit clock and an active-high frame marker. The block oversamples both lines with its own system clock and moves its serial data output one bit per bit-clock rising edge. The codec can therefore sample each bit on the falling edge that follows.

A frame has a fixed number of slots of fixed width. By default there are eight slots of 32 bit periods each. Each slot carries one sample, most significant bit first and left-aligned. The bit periods that remain after the sample are zero. Software-side logic loads samples through a parallel write port into per-slot shadow registers. Every shadow register is copied into an active register when a frame begins, so a frame never mixes old and new data.

A slot may be disabled for the whole of a frame, in which case it drives low. When an enabled slot starts without a new write since the previous frame began, the block sends the previous sample again and raises a flag for that slot's duration. Marker pulses that arrive while a frame is still in progress are ignored. A marker seen on the rising edge that drives a frame's final bit starts the next frame without a gap.

Top module: `tdm_slot_tx`

## Requirements
- R1: While reset is asserted and right after it, `sdata_o` and `underrun_o` are low.
- R2: When `fsync_i` is sampled high at a bit-clock rising edge and the marker is accepted, the next rising edge drives the most significant bit of slot 0. This is a delay of one bit. The frame then runs for NUM_SLOTS*SLOT_BITS (256) bit periods, and slot s occupies bit periods 32*s to 32*s+31.
- R3: Within a slot, bit period p (0..23) carries bit 23-p of the slot's 24-bit sample. Bit periods 24..31 are low.
- R4: `sdata_o` and `underrun_o` change only within four system-clock cycles after a bit-clock rising edge. They hold steady until the next rising edge.
- R5: A marker that is sampled high at any rising edge of a running frame is ignored, except at the edge that drives the frame's last bit. An ignored marker does not realign or restart the frame.
- R6: A marker that is sampled high at the rising edge driving bit 255 starts the next frame at the following edge, with no gap.
- R7: After bit 255 of a frame, if no marker was accepted, the output stays low and no flag is raised until an accepted marker starts a new frame.
- R8: `slot_en_i[s]` enables slot s. The enable vector is captured when a frame begins and holds for that frame. A disabled slot drives low and never raises `underrun_o`.
- R9: A write (`wr_en_i` high for one system clock) stores `wr_data_i` in the shadow register of slot `wr_slot_i`. All shadow registers are copied to the active registers when a frame begins, so a write made during a frame takes effect in the next frame.
- R10: If an enabled slot starts a frame without a write to its shadow register since the previous frame began, the slot repeats its shadow value. A slot that has never been written since reset repeats zero. `underrun_o` is high for that slot's 32 bit periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bit clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Bit clock from the codec |
| fsync_i | input | 1 | Active-high frame marker from the codec |
| slot_en_i | input | NUM_SLOTS | Per-slot enable, captured at frame start |
| wr_en_i | input | 1 | Write strobe for a slot sample |
| wr_slot_i | input | clog2(NUM_SLOTS) | Slot number of the write |
| wr_data_i | input | SAMPLE_BITS | Sample written to the slot's shadow register |
| sdata_o | output | 1 | Serial data to the codec |
| underrun_o | output | 1 | High during an enabled slot that repeats old data |

## Verification
The bench sends a marker in the middle of a frame. A design that resynchronised on it would shift every later bit, and the serial compare would fail at once. It also holds the marker high for two bit periods while the link is idle, which a design would wrongly accept twice. It chains two frames back to back and then lets the link go idle, so an off-by-one frame length or a missed final marker shows up as a frame that starts late, starts early or never starts. Writes land in the middle of a frame, and the enable vector changes one frame ahead of use. A design without the shadow copy would change samples mid-frame. A design with a wrong stale-data rule would flag fresh slots or miss flags on disabled or stale slots. An all-ones sample exposes any leak into the zero pad bits.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    // Default geometry of the link
    localparam int unsigned DEF_NUM_SLOTS   = 8;
    localparam int unsigned DEF_SLOT_BITS   = 32;
    localparam int unsigned DEF_SAMPLE_BITS = 24;
    localparam int unsigned DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/tdm_tx_edge_sync.sv
// Brings the codec's bit clock and frame marker into the system clock domain
// and flags each bit-clock rising edge with a one-cycle pulse.
module tdm_tx_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic bclk_i,
    input  logic fsync_i,
    output logic rise_o,
    output logic fsync_o
);

    typedef struct packed {
        logic [STAGES-1:0] bclk_sh;
        logic [STAGES-1:0] fs_sh;
        logic              bclk_prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.bclk_sh   = {st_q.bclk_sh[STAGES-2:0], bclk_i};
        st_d.fs_sh     = {st_q.fs_sh[STAGES-2:0], fsync_i};
        st_d.bclk_prev = st_q.bclk_sh[STAGES-1];
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rise_o  = st_q.bclk_sh[STAGES-1] & ~st_q.bclk_prev;
    assign fsync_o = st_q.fs_sh[STAGES-1];

    // R4: a rising edge is reported once, never on two cycles in a row
    a_r4_one_pulse_per_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);

endmodule

// File: rtl/tdm_tx_slot_store.sv
// Shadow and active sample registers, captured enables and stale marks.
// Outputs show the values that hold after this cycle's frame start, if any.
module tdm_tx_slot_store #(
    parameter int unsigned NUM_SLOTS   = 8,
    parameter int unsigned SAMPLE_BITS = 24,
    localparam int unsigned SLOT_W     = $clog2(NUM_SLOTS)
) (
    input  logic                                  clk_i,
    input  logic                                  rst_ni,
    input  logic                                  frame_start_i,
    input  logic [NUM_SLOTS-1:0]                  slot_en_i,
    input  logic                                  wr_en_i,
    input  logic [SLOT_W-1:0]                     wr_slot_i,
    input  logic [SAMPLE_BITS-1:0]                wr_data_i,
    output logic [NUM_SLOTS-1:0][SAMPLE_BITS-1:0] words_o,
    output logic [NUM_SLOTS-1:0]                  en_o,
    output logic [NUM_SLOTS-1:0]                  stale_o
);

    typedef struct packed {
        logic [NUM_SLOTS-1:0][SAMPLE_BITS-1:0] shadow;
        logic [NUM_SLOTS-1:0][SAMPLE_BITS-1:0] act;
        logic [NUM_SLOTS-1:0]                  fresh;
        logic [NUM_SLOTS-1:0]                  stale;
        logic [NUM_SLOTS-1:0]                  en;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_start_i) begin
            st_d.act   = st_q.shadow;
            st_d.en    = slot_en_i;
            st_d.stale = ~st_q.fresh;
            st_d.fresh = '0;
        end
        // a write in the same cycle as a frame start counts for the next frame
        if (wr_en_i) begin
            st_d.shadow[wr_slot_i] = wr_data_i;
            st_d.fresh[wr_slot_i]  = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign words_o = st_d.act;
    assign en_o    = st_d.en;
    assign stale_o = st_d.stale;

    // R9: a write always leaves its slot marked fresh
    a_r9_write_sets_fresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> st_q.fresh[$past(wr_slot_i)]);

    // R9: active samples only move at a frame start
    a_r9_active_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !frame_start_i |=> $stable(st_q.act));

endmodule

// File: rtl/tdm_tx_framer.sv
// Frame position tracking, marker acceptance with one-bit delay, and the
// serial output bit.
module tdm_tx_framer #(
    parameter int unsigned NUM_SLOTS   = 8,
    parameter int unsigned SLOT_BITS   = 32,
    parameter int unsigned SAMPLE_BITS = 24,
    localparam int unsigned FRAME_BITS = NUM_SLOTS * SLOT_BITS,
    localparam int unsigned CNT_W      = $clog2(FRAME_BITS),
    localparam int unsigned POS_W      = $clog2(SLOT_BITS),
    localparam int unsigned SLOT_W     = CNT_W - POS_W
) (
    input  logic                                  clk_i,
    input  logic                                  rst_ni,
    input  logic                                  rise_i,
    input  logic                                  fsync_i,
    input  logic [NUM_SLOTS-1:0][SAMPLE_BITS-1:0] words_i,
    input  logic [NUM_SLOTS-1:0]                  en_i,
    input  logic [NUM_SLOTS-1:0]                  stale_i,
    output logic                                  frame_start_o,
    output logic                                  sdata_o,
    output logic                                  underrun_o
);

    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_BITS - 1);
    localparam logic [POS_W:0]   PAD_START = (POS_W+1)'(SAMPLE_BITS);
    localparam logic [POS_W-1:0] TOP_BIT   = POS_W'(SAMPLE_BITS - 1);

    typedef struct packed {
        logic             active;
        logic             pend;
        logic [CNT_W-1:0] cnt;
        logic             sdata;
        logic             under;
    } frm_t;

    frm_t              st_d, st_q;
    logic [SLOT_W-1:0] slot;
    logic [POS_W-1:0]  pos;
    logic [POS_W-1:0]  bidx;

    // an accepted marker starts the frame on the next bit-clock rise
    assign frame_start_o = rise_i & st_q.pend;

    always_comb begin
        st_d = st_q;
        slot = '0;
        pos  = '0;
        bidx = '0;
        if (rise_i) begin
            if (st_q.pend) begin
                st_d.active = 1'b1;
                st_d.cnt    = '0;
            end else if (st_q.active) begin
                if (st_q.cnt == LAST_BIT) st_d.active = 1'b0;
                else                      st_d.cnt    = st_q.cnt + 1'b1;
            end
            // accept only while idle or when the bit now driven is the last one
            st_d.pend = fsync_i && (!st_d.active || st_d.cnt == LAST_BIT);

            slot = st_d.cnt[CNT_W-1:POS_W];
            pos  = st_d.cnt[POS_W-1:0];
            bidx = TOP_BIT - pos;
            st_d.sdata = 1'b0;
            st_d.under = 1'b0;
            if (st_d.active && en_i[slot]) begin
                st_d.under = stale_i[slot];
                if ({1'b0, pos} < PAD_START) st_d.sdata = words_i[slot][bidx];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sdata_o    = st_q.sdata;
    assign underrun_o = st_q.under;

    // R4: outputs hold between bit-clock rises
    a_r4_hold_between_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rise_i |=> ($stable(sdata_o) && $stable(underrun_o)));

    // R5: inside a frame every rise advances by exactly one bit
    a_r5_no_early_resync: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise_i && st_q.active && st_q.cnt != LAST_BIT)
        |=> (st_q.active && st_q.cnt == $past(st_q.cnt) + 1'b1));

    // R7: nothing is driven while no frame runs
    a_r7_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.active |-> (!sdata_o && !underrun_o));

    // R10: the flag is only ever raised inside a frame
    a_r10_underrun_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
        underrun_o |-> st_q.active);

endmodule

// File: rtl/tdm_slot_tx.sv
module tdm_slot_tx
    import tdm_tx_pkg::*;
#(
    parameter int unsigned NUM_SLOTS   = DEF_NUM_SLOTS,
    parameter int unsigned SLOT_BITS   = DEF_SLOT_BITS,
    parameter int unsigned SAMPLE_BITS = DEF_SAMPLE_BITS,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
    localparam int unsigned SLOT_W     = $clog2(NUM_SLOTS)
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   bclk_i,
    input  logic                   fsync_i,
    input  logic [NUM_SLOTS-1:0]   slot_en_i,
    input  logic                   wr_en_i,
    input  logic [SLOT_W-1:0]      wr_slot_i,
    input  logic [SAMPLE_BITS-1:0] wr_data_i,
    output logic                   sdata_o,
    output logic                   underrun_o
);

    logic                                  rise;
    logic                                  fsync_s;
    logic                                  frame_start;
    logic [NUM_SLOTS-1:0][SAMPLE_BITS-1:0] words;
    logic [NUM_SLOTS-1:0]                  en;
    logic [NUM_SLOTS-1:0]                  stale;

    tdm_tx_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .bclk_i  (bclk_i),
        .fsync_i (fsync_i),
        .rise_o  (rise),
        .fsync_o (fsync_s)
    );

    tdm_tx_slot_store #(
        .NUM_SLOTS   (NUM_SLOTS),
        .SAMPLE_BITS (SAMPLE_BITS)
    ) i_store (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .frame_start_i (frame_start),
        .slot_en_i     (slot_en_i),
        .wr_en_i       (wr_en_i),
        .wr_slot_i     (wr_slot_i),
        .wr_data_i     (wr_data_i),
        .words_o       (words),
        .en_o          (en),
        .stale_o       (stale)
    );

    tdm_tx_framer #(
        .NUM_SLOTS   (NUM_SLOTS),
        .SLOT_BITS   (SLOT_BITS),
        .SAMPLE_BITS (SAMPLE_BITS)
    ) i_framer (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .rise_i        (rise),
        .fsync_i       (fsync_s),
        .words_i       (words),
        .en_i          (en),
        .stale_i       (stale),
        .frame_start_o (frame_start),
        .sdata_o       (sdata_o),
        .underrun_o    (underrun_o)
    );

endmodule

// File: tb/test_tdm_slot_tx.sv
module test_tdm_slot_tx;

    localparam int NS = 8;
    localparam int SB = 32;
    localparam int SW = 24;
    localparam int FB = NS * SB;

    typedef struct {
        logic  sd;
        logic  ur;
        string tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bclk = 1'b0;
    logic          fsync = 1'b0;
    logic [NS-1:0] slot_en = '1;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_slot = '0;
    logic [SW-1:0] wr_data = '0;
    logic          sdata;
    logic          underrun;

    int    total = 0;
    int    bad = 0;
    bit    finished = 1'b0;
    item_t expq[$];
    string ftag = "R2";

    // reference model state
    bit            m_act = 1'b0;
    bit            m_pend = 1'b0;
    int            m_cnt = 0;
    logic [SW-1:0] m_sh   [NS];
    logic [SW-1:0] m_word [NS];
    bit            m_fresh[NS];
    bit            m_stale[NS];
    logic [NS-1:0] m_en = '0;

    always #2.5 clk = ~clk;

    tdm_slot_tx i_tdm_slot_tx (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .bclk_i     (bclk),
        .fsync_i    (fsync),
        .slot_en_i  (slot_en),
        .wr_en_i    (wr_en),
        .wr_slot_i  (wr_slot),
        .wr_data_i  (wr_data),
        .sdata_o    (sdata),
        .underrun_o (underrun)
    );

    task automatic check(input string req, input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // model of one bit-clock rise; pushes the value expected after it
    task automatic model_rise(input logic fs);
        item_t it;
        int    s;
        int    p;
        if (m_pend) begin
            m_act = 1'b1;
            m_cnt = 0;
            m_en  = slot_en;
            for (int i = 0; i < NS; i++) begin
                m_word[i]  = m_sh[i];
                m_stale[i] = !m_fresh[i];
                m_fresh[i] = 1'b0;
            end
        end else if (m_act) begin
            if (m_cnt == FB - 1) m_act = 1'b0;
            else                 m_cnt++;
        end
        m_pend = fs && (!m_act || m_cnt == FB - 1);
        s = m_cnt / SB;
        p = m_cnt % SB;
        it.sd = 1'b0;
        it.ur = 1'b0;
        if (!m_act)          it.tag = "R7";
        else if (!m_en[s])   it.tag = "R8";
        else begin
            it.ur = m_stale[s];
            if (p < SW) begin
                it.sd  = m_word[s][SW-1-p];
                it.tag = m_stale[s] ? "R10" : "R3";
            end else begin
                it.tag = "R3";
            end
        end
        it.tag = {it.tag, " ", ftag, " R4"};
        expq.push_back(it);
    endtask

    task automatic bit_cycle(input logic fs);
        bclk  = 1'b0;
        fsync = fs;
        #40;
        bclk = 1'b1;
        model_rise(fs);
        #40;
    endtask

    task automatic write_slot(input int s, input logic [SW-1:0] v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_slot = 3'(s);
        wr_data = v;
        m_sh[s]    = v;
        m_fresh[s] = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic frame(input bit chain, input int early_k, input int wr_k,
                         input logic [NS-1:0] wr_mask, input logic [SW-1:0] wr_v,
                         input int en_k, input logic [NS-1:0] en_v);
        for (int k = 0; k < FB; k++) begin
            bit_cycle((chain && k == FB - 1) || k == early_k);
            if (k == wr_k)
                for (int s = 0; s < NS; s++)
                    if (wr_mask[s]) write_slot(s, wr_v ^ (SW'(s) * 24'h010101));
            if (k == en_k) slot_en = en_v;
        end
    endtask

    // monitor: compare at the codec's sampling edge
    always @(negedge bclk) begin
        if (expq.size() > 0) begin
            item_t it;
            it = expq.pop_front();
            check(it.tag, sdata, it.sd, "sdata");
            check(it.tag, underrun, it.ur, "underrun");
        end
    end

    initial begin
        for (int i = 0; i < NS; i++) begin
            m_sh[i] = '0; m_word[i] = '0; m_fresh[i] = 1'b0; m_stale[i] = 1'b0;
        end
        #100;
        check("R1", sdata, 1'b0, "sdata in reset");
        check("R1", underrun, 1'b0, "underrun in reset");
        @(negedge clk);
        rst_n = 1'b1;
        #20;
        check("R1", sdata, 1'b0, "sdata after reset");
        check("R1", underrun, 1'b0, "underrun after reset");

        ftag = "R7";
        for (int k = 0; k < 3; k++) bit_cycle(1'b0);
        for (int s = 0; s < NS; s++) write_slot(s, 24'hA5C3F0 ^ (SW'(s) * 24'h111111));

        // frame 1: mid-frame marker ignored, writes land for next frame, chain on
        ftag = "R2 R5 R9";
        bit_cycle(1'b1);
        frame(1'b1, 100, 50, 8'b0010_1001, 24'h3C5A96, 200, 8'hA5);

        // frame 2: back-to-back, mixed enables and stale slots, refill all
        ftag = "R6 R8 R10 R9";
        frame(1'b0, 3, 120, 8'hFF, 24'hFFFFFF, 200, 8'hFF);

        // idle, then a marker held for two bit periods
        ftag = "R7";
        for (int k = 0; k < 3; k++) bit_cycle(1'b0);
        ftag = "R5 R3";
        bit_cycle(1'b1);
        frame(1'b0, 0, -1, 8'h00, 24'h0, -1, 8'hFF);

        ftag = "R7";
        for (int k = 0; k < 4; k++) bit_cycle(1'b0);
        bclk = 1'b0;
        #40;
        check("R7", sdata, 1'b0, "sdata at end");
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500us;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule